// File: doc/BRIEF.md
# Floating-Point Coprocessor Status Word

This block keeps the 16-bit status word of a stack-based floating-point coprocessor. The word holds a 3-bit index of the register now at the top of the stack, six sticky exception flags, an error-summary bit and four condition-code bits. The execution unit reports exceptions, moves the stack with push and pop strobes, and writes condition codes through per-bit enables. Software-visible commands can clear the flags or load the whole word. The error-summary bit is formed from the flags and the exception mask taken from the control word, and it drives an external ERROR pin.

The block also records, for each new instruction, the address of that instruction, the address of its memory operand when it has one, and its 11-bit opcode. The mode input picks the format for the two addresses. Real mode keeps a 20-bit physical address. Protected mode keeps a 32-bit virtual address.

Every update is a single-cycle strobe that is always accepted. No input has back-pressure, so there is no valid/ready pairing. Each strobe takes effect at the next rising clock edge. ERROR follows the flags and the mask through logic only.

Top module: `fpu_status_unit`

## Requirements
- R1: After reset the status word is 0x0000, error_o is 0, and ip_o, dp_o and opcode_o are zero.
- R2: Bits 14:12 hold TOP. A push alone decrements TOP modulo 8 at the next edge. A pop alone increments TOP modulo 8. A push and a pop in the same cycle leave TOP unchanged.
- R3: When exc_valid is high, each set bit n of exc_flags sets status bit n (bits 5:0) at the next edge. A flag stays set until a clear or a load removes it.
- R4: clr_exc zeroes bits 5:0 at the next edge. Exceptions reported in that same cycle are still recorded afterwards.
- R5: Bit 7 is 1 exactly when some flag is set whose exc_mask bit is 0 (a mask bit of 1 masks the flag). error_o always equals bit 7. A change of exc_mask alone shows on error_o in the same cycle.
- R6: Condition codes C0, C1, C2 and C3 sit at bits 8, 9, 10 and 11. At the next edge each bit with cc_we[i]=1 takes cc_wdata[i]. Each bit with cc_we[i]=0 keeps its value.
- R7: ld_valid loads TOP, the condition codes and the flags from the same bit positions of ld_word. The load overrides push, pop, condition-code writes, clear and exception reports in that cycle. Bits 15 and 6 always read 0, and bit 7 is recomputed from the loaded flags.
- R8: instr_valid captures the instruction address into ip_o, the opcode into opcode_o and the mode into ptr_mode_o at the next edge. dp_o is captured only when instr_has_opnd is 1 and otherwise keeps its value.
- R9: When instr_mode is 0 (real), the captured addresses keep only their low 20 bits and the upper 12 bits read 0. When instr_mode is 1 (protected), all 32 bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception report strobe |
| exc_flags | input | 6 | Exceptions detected by the execution unit |
| exc_mask | input | 6 | Mask bits from the control word, 1 = masked |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| cc_we | input | 4 | Per-bit condition-code write enables |
| cc_wdata | input | 4 | Condition-code write values |
| clr_exc | input | 1 | Clear all exception flags |
| ld_valid | input | 1 | Load whole status word |
| ld_word | input | 16 | Status word to load |
| instr_valid | input | 1 | New instruction capture strobe |
| instr_mode | input | 1 | 0 = real, 1 = protected |
| instr_addr | input | 32 | Instruction address |
| instr_has_opnd | input | 1 | Instruction has a memory operand |
| opnd_addr | input | 32 | Operand address |
| instr_opcode | input | 11 | Instruction opcode |
| status_word | output | 16 | Full status word |
| error_o | output | 1 | Unmasked exception pending |
| ip_o | output | 32 | Captured instruction address |
| dp_o | output | 32 | Captured operand address |
| opcode_o | output | 11 | Captured opcode |
| ptr_mode_o | output | 1 | Mode in which the pointers were captured |

## Verification
The assertions assume that exc_mask is stable across each rising edge, and that a load command's word has a meaning only in the bits it defines. Under that assumption ERROR can be compared with the flags at the edge. They also assume that push and pop come from one sequencer, which may raise both in one cycle. The bench changes every input only on the falling edge. In some cycles it combines push with pop, clear with a report, and a load with every other command, so each precedence rule is exercised inside these assumptions.

// File: rtl/fpu_sw_pkg.sv
package fpu_sw_pkg;
  localparam int SW_W      = 16;
  localparam int TOP_W     = 3;
  localparam int N_EXC     = 6;
  localparam int N_CC      = 4;
  localparam int TOP_LSB   = 12;
  localparam int CC_LSB    = 8;
  localparam int ES_BIT    = 7;
  localparam int VADDR_W   = 32;
  localparam int PADDR_W   = 20;
  localparam int OPC_W     = 11;

  typedef enum logic {
    MODE_REAL  = 1'b0,
    MODE_PROT  = 1'b1
  } addr_mode_e;

  typedef enum logic [1:0] {
    STK_HOLD = 2'b00,
    STK_DEC  = 2'b01,
    STK_INC  = 2'b10
  } stk_op_e;
endpackage

// File: rtl/sw_top_ptr.sv
module sw_top_ptr
  import fpu_sw_pkg::*;
#(
  parameter int W = TOP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         ld,
  input  logic [W-1:0] ld_top,
  output logic [W-1:0] top
);
  stk_op_e      op;
  logic [W-1:0] top_nxt;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    if (push && !pop)      op = STK_DEC;
    else if (pop && !push) op = STK_INC;
    else                   op = STK_HOLD;
  end

  always_comb begin
    unique case (op)
      STK_DEC: top_nxt = top - ONE;
      STK_INC: top_nxt = top + ONE;
      default: top_nxt = top;
    endcase
    if (ld) top_nxt = ld_top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) top <= '0;
    else        top <= top_nxt;
  end
endmodule

// File: rtl/sw_exc_flags.sv
module sw_exc_flags
  import fpu_sw_pkg::*;
#(
  parameter int N = N_EXC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exc_valid,
  input  logic [N-1:0] exc_in,
  input  logic         clr,
  input  logic         ld,
  input  logic [N-1:0] ld_flags,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         summary
);
  logic [N-1:0] kept;
  logic [N-1:0] raised;
  logic [N-1:0] flags_nxt;
  logic [N-1:0] live;

  always_comb begin
    kept      = clr ? '0 : flags;
    raised    = exc_valid ? exc_in : '0;
    flags_nxt = ld ? ld_flags : (kept | raised);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nxt;
  end

  // Unmasked flags reduce to the summary without a register.
  generate
    for (genvar i = 0; i < N; i++) begin : g_live
      assign live[i] = flags[i] & ~mask[i];
    end
  endgenerate

  assign summary = |live;
endmodule

// File: rtl/sw_cond_code.sv
module sw_cond_code
  import fpu_sw_pkg::*;
#(
  parameter int N = N_CC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] we,
  input  logic [N-1:0] wdata,
  input  logic         ld,
  input  logic [N-1:0] ld_cc,
  output logic [N-1:0] cc
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)     cc[i] <= 1'b0;
        else if (ld)    cc[i] <= ld_cc[i];
        else if (we[i]) cc[i] <= wdata[i];
      end
    end
  endgenerate
endmodule

// File: rtl/sw_ptr_capture.sv
module sw_ptr_capture
  import fpu_sw_pkg::*;
#(
  parameter int AW  = VADDR_W,
  parameter int PAW = PADDR_W,
  parameter int OW  = OPC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          mode,
  input  logic [AW-1:0] iaddr,
  input  logic          has_opnd,
  input  logic [AW-1:0] daddr,
  input  logic [OW-1:0] opc,
  output logic [AW-1:0] ip,
  output logic [AW-1:0] dp,
  output logic [OW-1:0] opc_q,
  output logic          mode_q
);
  localparam int HI_W = AW - PAW;
  logic [AW-1:0] ip_fmt;
  logic [AW-1:0] dp_fmt;

  function automatic logic [AW-1:0] fmt(input logic [AW-1:0] a, input logic m);
    if (addr_mode_e'(m) == MODE_PROT) return a;
    return {{HI_W{1'b0}}, a[PAW-1:0]};
  endfunction

  always_comb begin
    ip_fmt = fmt(iaddr, mode);
    dp_fmt = fmt(daddr, mode);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ip     <= '0;
      dp     <= '0;
      opc_q  <= '0;
      mode_q <= 1'b0;
    end else if (cap) begin
      ip     <= ip_fmt;
      opc_q  <= opc;
      mode_q <= mode;
      if (has_opnd) dp <= dp_fmt;
    end
  end
endmodule

// File: rtl/fpu_status_unit.sv
module fpu_status_unit
  import fpu_sw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                exc_valid,
  input  logic [N_EXC-1:0]    exc_flags,
  input  logic [N_EXC-1:0]    exc_mask,
  input  logic                push,
  input  logic                pop,
  input  logic [N_CC-1:0]     cc_we,
  input  logic [N_CC-1:0]     cc_wdata,
  input  logic                clr_exc,
  input  logic                ld_valid,
  input  logic [SW_W-1:0]     ld_word,
  input  logic                instr_valid,
  input  logic                instr_mode,
  input  logic [VADDR_W-1:0]  instr_addr,
  input  logic                instr_has_opnd,
  input  logic [VADDR_W-1:0]  opnd_addr,
  input  logic [OPC_W-1:0]    instr_opcode,
  output logic [SW_W-1:0]     status_word,
  output logic                error_o,
  output logic [VADDR_W-1:0]  ip_o,
  output logic [VADDR_W-1:0]  dp_o,
  output logic [OPC_W-1:0]    opcode_o,
  output logic                ptr_mode_o
);
  logic [TOP_W-1:0] top;
  logic [N_EXC-1:0] flags;
  logic [N_CC-1:0]  cc;
  logic             es;

  sw_top_ptr #(.W(TOP_W)) u_top (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .ld(ld_valid), .ld_top(ld_word[TOP_LSB +: TOP_W]), .top(top)
  );

  sw_exc_flags #(.N(N_EXC)) u_exc (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_in(exc_flags),
    .clr(clr_exc), .ld(ld_valid), .ld_flags(ld_word[N_EXC-1:0]),
    .mask(exc_mask), .flags(flags), .summary(es)
  );

  sw_cond_code #(.N(N_CC)) u_cc (
    .clk(clk), .rst_n(rst_n), .we(cc_we), .wdata(cc_wdata),
    .ld(ld_valid), .ld_cc(ld_word[CC_LSB +: N_CC]), .cc(cc)
  );

  sw_ptr_capture #(.AW(VADDR_W), .PAW(PADDR_W), .OW(OPC_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cap(instr_valid), .mode(instr_mode),
    .iaddr(instr_addr), .has_opnd(instr_has_opnd), .daddr(opnd_addr),
    .opc(instr_opcode), .ip(ip_o), .dp(dp_o), .opc_q(opcode_o),
    .mode_q(ptr_mode_o)
  );

  // Unlisted positions (15 and 6) read as zero.
  always_comb begin
    status_word                      = '0;
    status_word[N_EXC-1:0]           = flags;
    status_word[ES_BIT]              = es;
    status_word[CC_LSB +: N_CC]      = cc;
    status_word[TOP_LSB +: TOP_W]    = top;
  end

  assign error_o = es;
endmodule

// File: rtl/fpu_status_unit_chk.sv
module fpu_status_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_valid,
  input logic [5:0]  exc_flags,
  input logic [5:0]  exc_mask,
  input logic        push,
  input logic        pop,
  input logic [3:0]  cc_we,
  input logic        clr_exc,
  input logic        ld_valid,
  input logic [15:0] ld_word,
  input logic        instr_valid,
  input logic        instr_mode,
  input logic        instr_has_opnd,
  input logic [15:0] status_word,
  input logic        error_o,
  input logic [31:0] ip_o,
  input logic [31:0] dp_o
);
  assert_top_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !ld_valid) |=> status_word[14:12] == $past(status_word[14:12]) - 3'd1);

  assert_top_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !ld_valid) |=> status_word[14:12] == $past(status_word[14:12]) + 3'd1);

  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_exc && !ld_valid) |=> (status_word[5:0] & $past(status_word[5:0])) == $past(status_word[5:0]));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_exc && !ld_valid && !exc_valid) |=> status_word[5:0] == 6'd0);

  assert_error_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error_o == (|(status_word[5:0] & ~exc_mask)));

  assert_error_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    error_o == status_word[7]);

  assert_cc_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we == 4'd0 && !ld_valid) |=> $stable(status_word[11:8]));

  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (status_word[14:8] == $past(ld_word[14:8])) &&
                 (status_word[5:0] == $past(ld_word[5:0])) &&
                 !status_word[15] && !status_word[6]);

  assert_dp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && instr_has_opnd) |=> $stable(dp_o));

  assert_real_trunc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !instr_mode) |=> ip_o[31:20] == 12'd0);
endmodule

bind fpu_status_unit fpu_status_unit_chk u_chk (.*);

// File: tb/fpu_status_unit_bench.sv
module fpu_status_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        exc_valid = 0, push = 0, pop = 0, clr_exc = 0, ld_valid = 0;
  logic        instr_valid = 0, instr_mode = 0, instr_has_opnd = 0;
  logic [5:0]  exc_flags = 0, exc_mask = 6'h3F;
  logic [3:0]  cc_we = 0, cc_wdata = 0;
  logic [15:0] ld_word = 0;
  logic [31:0] instr_addr = 0, opnd_addr = 0;
  logic [10:0] instr_opcode = 0;
  logic [15:0] status_word;
  logic        error_o, ptr_mode_o;
  logic [31:0] ip_o, dp_o;
  logic [10:0] opcode_o;

  fpu_status_unit u_fpu_status_unit (.*);

  typedef struct {
    logic [15:0] sw;
    logic        err;
    logic [31:0] ip;
    logic [31:0] dp;
    logic [10:0] opc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [2:0]  m_top = 0;
  logic [5:0]  m_flags = 0;
  logic [3:0]  m_cc = 0;
  logic [31:0] m_ip = 0, m_dp = 0;
  logic [10:0] m_opc = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fmt(logic [31:0] a, logic m);
    return m ? a : {12'd0, a[19:0]};
  endfunction

  // Driver: apply current inputs for one cycle, update model, queue expectation.
  task automatic step(string tag);
    exp_t e;
    if (ld_valid) begin
      m_top = ld_word[14:12]; m_flags = ld_word[5:0]; m_cc = ld_word[11:8];
    end else begin
      if (push && !pop) m_top = m_top - 3'd1;
      if (pop && !push) m_top = m_top + 3'd1;
      m_flags = (clr_exc ? 6'd0 : m_flags) | (exc_valid ? exc_flags : 6'd0);
      m_cc = (m_cc & ~cc_we) | (cc_wdata & cc_we);
    end
    if (instr_valid) begin
      m_ip = fmt(instr_addr, instr_mode);
      m_opc = instr_opcode;
      if (instr_has_opnd) m_dp = fmt(opnd_addr, instr_mode);
    end
    e.err = |(m_flags & ~exc_mask);
    e.sw  = {1'b0, m_top, m_cc, e.err, 1'b0, m_flags};
    e.ip = m_ip; e.dp = m_dp; e.opc = m_opc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    exc_valid = 0; push = 0; pop = 0; clr_exc = 0; ld_valid = 0;
    instr_valid = 0; cc_we = 0;
  endtask

  // Monitor: compare a quarter period after each edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        check(e.tag, "status_word", {16'd0, status_word}, {16'd0, e.sw});
        check(e.tag, "error_o", {31'd0, error_o}, {31'd0, e.err});
        check(e.tag, "ip_o", ip_o, e.ip);
        check(e.tag, "dp_o", dp_o, e.dp);
        check(e.tag, "opcode_o", {21'd0, opcode_o}, {21'd0, e.opc});
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #15;
    check("R1", "reset status", {16'd0, status_word}, 32'd0);
    check("R1", "reset error", {31'd0, error_o}, 32'd0);
    check("R1", "reset ip", ip_o, 32'd0);
    check("R1", "reset dp", dp_o, 32'd0);
    @(negedge clk);

    push = 1; step("R2 push wrap");
    push = 1; step("R2 push");
    pop = 1;  step("R2 pop");
    pop = 1;  step("R2 pop wrap");
    push = 1; pop = 1; step("R2 push+pop");
    for (int i = 0; i < 9; i++) begin pop = 1; step("R2 pop loop"); end

    exc_valid = 1; exc_flags = 6'h05; step("R3 masked report");
    exc_mask = 6'h3E; step("R5 unmask bit0");
    exc_valid = 1; exc_flags = 6'h10; step("R3 sticky or");
    step("R3 idle hold");
    exc_mask = 6'h3F; step("R5 mask all");
    exc_mask = 6'h2F; step("R5 unmask bit4");
    clr_exc = 1; step("R4 clear");
    clr_exc = 1; exc_valid = 1; exc_flags = 6'h02; step("R4 clear with report");

    cc_we = 4'hF; cc_wdata = 4'hA; step("R6 write all");
    cc_we = 4'h1; cc_wdata = 4'h5; step("R6 partial write");
    cc_we = 4'h8; cc_wdata = 4'h0; step("R6 clear C3");

    exc_mask = 6'h00;
    ld_valid = 1; ld_word = 16'hFFFF; push = 1; exc_valid = 1; exc_flags = 6'h3F;
    cc_we = 4'hF; cc_wdata = 4'h0; clr_exc = 1; step("R7 load overrides");
    ld_valid = 1; ld_word = 16'h3500; step("R7 load clears flags");

    instr_valid = 1; instr_mode = 0; instr_addr = 32'hABCDE123;
    instr_has_opnd = 1; opnd_addr = 32'h12345678; instr_opcode = 11'h5A5;
    step("R9 real capture");
    instr_valid = 1; instr_mode = 1; instr_addr = 32'hFEDC0042;
    instr_has_opnd = 0; opnd_addr = 32'h0BADF00D; instr_opcode = 11'h123;
    step("R8 no operand hold");
    instr_valid = 1; instr_mode = 1; instr_addr = 32'h80001000;
    instr_has_opnd = 1; opnd_addr = 32'hCAFE0004; instr_opcode = 11'h7FF;
    step("R9 protected capture");
    instr_addr = 32'h11111111; instr_opcode = 11'h001; step("R8 no strobe hold");

    repeat (3) @(negedge clk);
    check("R8", "ptr_mode_o", {31'd0, ptr_mode_o}, 32'd1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule